// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command pins of a four-bank, 32-bit synchronous DRAM from reset until the memory is ready for use. While reset is asserted, and for a programmable settling interval afterwards, it keeps clock enable and the byte masks high and leaves the command bus idle. It then issues a fixed sequence: one precharge of every bank, a parameterized number of auto-refresh commands, and a load of the mode register. A parameter chooses whether the refresh group comes before or after the mode load.

The mode word is assembled from four configuration inputs: burst length, burst ordering, read latency and write-burst behaviour. Before the load is issued, the block checks the word against the encodings the memory leaves undefined. If the word is illegal, the block raises an error flag and stops, and nothing more goes onto the bus. A fixed number of idle cycles follows every command. One such gap after the last command, a done flag rises and stays high until reset. Read and write traffic, periodic refresh and the data path belong to other blocks.

Top module: `sdram_init_seq`

## Requirements
- R1: Clock enable and data mask are 1 in reset and in every cycle after it.
- R2: After reset is released, the precharge appears on the outputs after the WAIT_CYC-th rising edge (WAIT_CYC = CLK_MHZ * WAIT_US). Before that, the bus is idle.
- R3: The precharge is encoded as select 0, row 0, column 1, write 0. Its address is 0x400 (only bit 10 set) and its bank is 0.
- R4: REF_CNT auto-refresh commands are issued (REF_CNT is at least 2). Each is select 0, row 0, column 0, write 1, with address 0 and bank 0.
- R5: With REF_FIRST=1 the order is precharge, refreshes, mode load. With REF_FIRST=0 it is precharge, mode load, refreshes.
- R6: The mode load is select 0, row 0, column 0, write 0, with bank 0. Its address has burst length in bits 2:0, burst ordering in bit 3 (1 = interleaved), read latency in bits 6:4, single-write in bit 9, and bits 10, 8 and 7 at 0.
- R7: The mode word is legal only when the latency code is 2 or 3 and the burst length code is 0 to 3, or 7 with sequential ordering. If it is illegal, the error flag is 1 from the cycle in which the mode load would appear and stays 1 until reset. In that case the mode load and every later command are suppressed, and done stays 0.
- R8: Exactly GAP_CYC idle cycles lie between two consecutive commands.
- R9: Done becomes 1 after the GAP_CYC+1-th edge following the last command and holds until reset.
- R10: On every cycle without a command, select, row, column and write are all 1, and address and bank are 0.
- R11: A synchronous active-low reset returns all outputs to the idle state with done and error at 0, and restarts the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_burst_len | input | 3 | Burst length code |
| cfg_interleave | input | 1 | Burst ordering, 1 = interleaved |
| cfg_read_lat | input | 3 | Read latency code |
| cfg_single_wr | input | 1 | 1 = single-beat writes |
| cmd_sel_n | output | 1 | Chip select, active low |
| cmd_row_n | output | 1 | Row strobe, active low |
| cmd_col_n | output | 1 | Column strobe, active low |
| cmd_wr_n | output | 1 | Write enable, active low |
| clk_en | output | 1 | Clock enable |
| data_mask | output | 4 | Byte masks |
| bank_addr | output | 2 | Bank address |
| mem_addr | output | 11 | Multiplexed address |
| init_done | output | 1 | Sequence complete |
| cfg_err | output | 1 | Illegal mode word |

## Verification
The bench builds two instances with a one-microsecond clock setting and short waits, so a whole sequence fits in a few dozen cycles. The first uses a five-cycle wait, two refreshes, refresh-first order and a two-cycle gap. The second uses a three-cycle wait, three refreshes, mode-first order and a one-cycle gap. With sequences this short, all 256 combinations of the four configuration inputs can be swept edge by edge through both orderings. That reaches every legal and reserved mode encoding, error suppression both before and after the refresh group, and the done timing for both gap lengths.

// File: rtl/sdram_init_pkg.sv
// Shared types and the mode-word legality rule for the init sequencer.
// Assumes a four-bank device with an 11-bit multiplexed address.
package sdram_init_pkg;
    localparam int ADDR_W = 11;
    localparam int BANK_W = 2;
    localparam int MASK_W = 4;

    typedef enum logic [1:0] {
        CMD_IDLE   = 2'd0,
        CMD_PRECH  = 2'd1,
        CMD_REFR   = 2'd2,
        CMD_MODE   = 2'd3
    } cmd_e;

    // Legal: latency 2 or 3; length 1/2/4/8, or full page only when sequential.
    function automatic logic mode_is_legal(input logic [2:0] blen,
                                           input logic       ilv,
                                           input logic [2:0] lat);
        logic lat_ok, len_ok;
        lat_ok = (lat == 3'd2) || (lat == 3'd3);
        len_ok = (blen <= 3'd3) || ((blen == 3'd7) && !ilv);
        return lat_ok && len_ok;
    endfunction
endpackage

// File: rtl/sdram_mode_word.sv
// Builds the mode-register address word from the configuration inputs and
// flags illegal combinations. Purely combinational; assumes static inputs.
module sdram_mode_word
    import sdram_init_pkg::*;
(
    input  logic [2:0]        burst_len,
    input  logic              interleave,
    input  logic [2:0]        read_lat,
    input  logic              single_wr,
    output logic [ADDR_W-1:0] word,
    output logic              legal
);
    // Pack fields; reserved bit 10 and test bits 8:7 stay zero.
    always_comb begin
        word       = '0;
        word[2:0]  = burst_len;
        word[3]    = interleave;
        word[6:4]  = read_lat;
        word[9]    = single_wr;
        legal      = mode_is_legal(burst_len, interleave, read_lat);
    end
endmodule

// File: rtl/sdram_init_ctrl.sv
// Step sequencer: counts the settling wait, then walks precharge, refreshes
// and mode load in the order chosen by REF_FIRST, with GAP_CYC idle cycles
// after each. Emits the command to issue on the next edge, plus done/error.
// Assumes WAIT_CYC >= 1, GAP_CYC >= 1, REF_CNT >= 2.
module sdram_init_ctrl
    import sdram_init_pkg::*;
#(
    parameter int WAIT_CYC  = 20000,
    parameter int GAP_CYC   = 2,
    parameter int REF_CNT   = 2,
    parameter bit REF_FIRST = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_ok,
    output cmd_e cmd_next,
    output logic done,
    output logic err
);
    localparam int STEPS  = REF_CNT + 2;
    localparam int CNT_MX = (WAIT_CYC > GAP_CYC) ? WAIT_CYC : GAP_CYC;
    localparam int CNT_W  = $clog2(CNT_MX + 1);
    localparam int STEP_W = $clog2(STEPS + 1);
    localparam int MODE_STEP = REF_FIRST ? STEPS - 1 : 1;

    typedef enum logic [1:0] {PH_RUN, PH_DONE, PH_ERR} phase_e;

    phase_e            phase;
    logic [CNT_W-1:0]  rem;
    logic [STEP_W-1:0] step;
    cmd_e              step_cmd;
    logic              fire;

    // Decode which command the current step stands for.
    always_comb begin
        if (step == '0)
            step_cmd = CMD_PRECH;
        else if (step == STEP_W'(MODE_STEP))
            step_cmd = CMD_MODE;
        else
            step_cmd = CMD_REFR;
    end

    assign fire = (phase == PH_RUN) && (rem == '0) && (step != STEP_W'(STEPS));

    // Select the command presented to the pin driver this cycle.
    always_comb begin
        cmd_next = CMD_IDLE;
        if (fire && !((step_cmd == CMD_MODE) && !mode_ok))
            cmd_next = step_cmd;
    end

    // Advance the wait counter, the step index and the terminal flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_RUN;
            rem   <= CNT_W'(WAIT_CYC - 1);
            step  <= '0;
            done  <= 1'b0;
            err   <= 1'b0;
        end else if (phase == PH_RUN) begin
            if (rem != '0) begin
                rem <= rem - 1'b1;
            end else if (step == STEP_W'(STEPS)) begin
                phase <= PH_DONE;
                done  <= 1'b1;
            end else if ((step_cmd == CMD_MODE) && !mode_ok) begin
                phase <= PH_ERR;
                err   <= 1'b1;
            end else begin
                rem  <= CNT_W'(GAP_CYC);
                step <= step + 1'b1;
            end
        end
    end

    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (err && !done));
    p_no_cmd_after_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> (cmd_next == CMD_IDLE));
endmodule

// File: rtl/sdram_cmd_drv.sv
// Registers the memory command pins from the selected command. Idle cycles
// carry deselect with all strobes high; clock enable and masks stay high.
module sdram_cmd_drv
    import sdram_init_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd,
    input  logic [ADDR_W-1:0] mode_word,
    output logic              sel_n,
    output logic              row_n,
    output logic              col_n,
    output logic              wr_n,
    output logic              clk_en,
    output logic [MASK_W-1:0] mask,
    output logic [BANK_W-1:0] bank,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << 10;

    // Encode the command into registered pin levels.
    always_ff @(posedge clk) begin
        clk_en <= 1'b1;
        mask   <= '1;
        bank   <= '0;
        if (!rst_n) begin
            {sel_n, row_n, col_n, wr_n} <= 4'b1111;
            addr <= '0;
        end else begin
            case (cmd)
                CMD_PRECH: begin {sel_n, row_n, col_n, wr_n} <= 4'b0010; addr <= ALL_BANKS; end
                CMD_REFR:  begin {sel_n, row_n, col_n, wr_n} <= 4'b0001; addr <= '0;        end
                CMD_MODE:  begin {sel_n, row_n, col_n, wr_n} <= 4'b0000; addr <= mode_word; end
                default:   begin {sel_n, row_n, col_n, wr_n} <= 4'b1111; addr <= '0;        end
            endcase
        end
    end

    p_pins_awake_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && (&mask));
    p_prech_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !row_n && col_n && !wr_n) |-> (addr == ALL_BANKS));
    p_mode_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !row_n && !col_n && !wr_n) |-> (bank == '0 && !addr[10] && addr[8:7] == 2'b00));
    p_cmd_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_n |=> sel_n);
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> (row_n && col_n && wr_n && addr == '0));
endmodule

// File: rtl/sdram_init_seq.sv
// Top of the power-up initialization sequencer. Derives the settling wait
// from clock frequency and wait time, builds and checks the mode word, and
// drives the command pins until done or error. Config inputs must be stable
// from reset release until the sequence ends.
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int CLK_MHZ   = 100,
    parameter int WAIT_US   = 200,
    parameter int REF_CNT   = 2,
    parameter bit REF_FIRST = 1'b1,
    parameter int GAP_CYC   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  cfg_burst_len,
    input  logic        cfg_interleave,
    input  logic [2:0]  cfg_read_lat,
    input  logic        cfg_single_wr,
    output logic        cmd_sel_n,
    output logic        cmd_row_n,
    output logic        cmd_col_n,
    output logic        cmd_wr_n,
    output logic        clk_en,
    output logic [3:0]  data_mask,
    output logic [1:0]  bank_addr,
    output logic [10:0] mem_addr,
    output logic        init_done,
    output logic        cfg_err
);
    localparam int WAIT_CYC = CLK_MHZ * WAIT_US;

    logic [ADDR_W-1:0] mode_word;
    logic              mode_ok;
    cmd_e              cmd_next;

    sdram_mode_word u_word (
        .burst_len (cfg_burst_len),
        .interleave(cfg_interleave),
        .read_lat  (cfg_read_lat),
        .single_wr (cfg_single_wr),
        .word      (mode_word),
        .legal     (mode_ok)
    );

    sdram_init_ctrl #(
        .WAIT_CYC (WAIT_CYC),
        .GAP_CYC  (GAP_CYC),
        .REF_CNT  (REF_CNT),
        .REF_FIRST(REF_FIRST)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_ok (mode_ok),
        .cmd_next(cmd_next),
        .done    (init_done),
        .err     (cfg_err)
    );

    sdram_cmd_drv u_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd_next),
        .mode_word(mode_word),
        .sel_n    (cmd_sel_n),
        .row_n    (cmd_row_n),
        .col_n    (cmd_col_n),
        .wr_n     (cmd_wr_n),
        .clk_en   (clk_en),
        .mask     (data_mask),
        .bank     (bank_addr),
        .addr     (mem_addr)
    );

    p_err_blocks_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> cmd_sel_n);
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (cmd_sel_n && !cfg_err));
endmodule

// File: tb/sdram_init_seq_tb.sv
// Sweeps every configuration input combination through two builds and
// compares all pins edge by edge with an arithmetic model of the sequence.
module sdram_init_seq_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] cfg_bl = '0;
    logic       cfg_ilv = 1'b0;
    logic [2:0] cfg_lat = '0;
    logic       cfg_sw = 1'b0;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    logic [20:0] obs [2];

    logic s0, r0, c0, w0, e0, i0, d0, x0; logic [3:0] m0; logic [1:0] b0; logic [10:0] a0;
    logic s1, r1, c1, w1, e1, i1, d1, x1; logic [3:0] m1; logic [1:0] b1; logic [10:0] a1;

    sdram_init_seq #(.CLK_MHZ(1), .WAIT_US(5), .REF_CNT(2), .REF_FIRST(1'b1), .GAP_CYC(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_burst_len(cfg_bl), .cfg_interleave(cfg_ilv),
        .cfg_read_lat(cfg_lat), .cfg_single_wr(cfg_sw), .cmd_sel_n(s0), .cmd_row_n(r0),
        .cmd_col_n(c0), .cmd_wr_n(w0), .clk_en(e0), .data_mask(m0), .bank_addr(b0),
        .mem_addr(a0), .init_done(d0), .cfg_err(x0));

    sdram_init_seq #(.CLK_MHZ(1), .WAIT_US(3), .REF_CNT(3), .REF_FIRST(1'b0), .GAP_CYC(1)) u_dut_alt (
        .clk(clk), .rst_n(rst_n), .cfg_burst_len(cfg_bl), .cfg_interleave(cfg_ilv),
        .cfg_read_lat(cfg_lat), .cfg_single_wr(cfg_sw), .cmd_sel_n(s1), .cmd_row_n(r1),
        .cmd_col_n(c1), .cmd_wr_n(w1), .clk_en(e1), .data_mask(m1), .bank_addr(b1),
        .mem_addr(a1), .init_done(d1), .cfg_err(x1));

    assign i0 = &m0;
    assign i1 = &m1;
    assign obs[0] = {s0, r0, c0, w0, e0, i0, b0, a0, d0, x0};
    assign obs[1] = {s1, r1, c1, w1, e1, i1, b1, a1, d1, x1};

    function automatic int p_wait(int i); return i == 0 ? 5 : 3; endfunction
    function automatic int p_gap(int i);  return i == 0 ? 2 : 1; endfunction
    function automatic int p_ref(int i);  return i == 0 ? 2 : 3; endfunction
    function automatic bit p_rf(int i);   return i == 0; endfunction

    function automatic int last_k(int i);
        return p_wait(i) - 1 + (p_ref(i) + 1) * (p_gap(i) + 1);
    endfunction

    // Expected pins after edge k (k = -1 means reset state); also a tag.
    function automatic logic [20:0] model(int i, int k, output string tag);
        logic [20:0] v;
        logic legal;
        int w, g, mstep, km, s;
        logic [10:0] mw;
        w = p_wait(i); g = p_gap(i);
        mstep = p_rf(i) ? p_ref(i) + 1 : 1;
        km = w - 1 + mstep * (g + 1);
        legal = (cfg_lat == 3'd2 || cfg_lat == 3'd3) &&
                (cfg_bl <= 3'd3 || (cfg_bl == 3'd7 && !cfg_ilv));
        mw = {1'b0, cfg_sw, 2'b00, cfg_lat, cfg_ilv, cfg_bl};
        v = {4'b1111, 1'b1, 1'b1, 2'b00, 11'd0, 1'b0, 1'b0};
        tag = "R8 R10";
        if (k < 0) begin
            tag = "R11";
        end else if (k < w - 1) begin
            tag = "R2";
        end else if (!legal && k >= km) begin
            v[0] = 1'b1; tag = "R7";
        end else if (k >= last_k(i) + g + 1) begin
            v[1] = 1'b1; tag = "R9";
        end else if ((k - (w - 1)) % (g + 1) == 0) begin
            s = (k - (w - 1)) / (g + 1);
            if (s == 0) begin
                v[20:17] = 4'b0010; v[12:2] = 11'h400; tag = "R3";
            end else if (s == mstep) begin
                v[20:17] = 4'b0000; v[12:2] = mw; tag = "R6 R5";
            end else begin
                v[20:17] = 4'b0001; tag = "R4 R5";
            end
        end
        return v;
    endfunction

    task automatic check_all(int k);
        for (int i = 0; i < 2; i++) begin
            string tag;
            logic [20:0] e;
            e = model(i, k, tag);
            n_vec++;
            if (obs[i] !== e) begin
                n_bad++;
                if (obs[i][16:15] !== 2'b11) tag = "R1";
                $display("FAIL %s inst%0d edge %0d cfg bl=%0d ilv=%0d lat=%0d sw=%0d: got %h exp %h",
                         tag, i, k, cfg_bl, cfg_ilv, cfg_lat, cfg_sw, obs[i], e);
            end
        end
    endtask

    initial begin
        int kmax;
        kmax = (last_k(0) > last_k(1) ? last_k(0) : last_k(1)) + 6;
        for (int c = 0; c < 256; c++) begin
            @(negedge clk);
            rst_n = 1'b0;
            {cfg_bl, cfg_ilv, cfg_lat, cfg_sw} = 8'(c);
            @(posedge clk);
            @(negedge clk);
            check_all(-1);
            rst_n = 1'b1;
            for (int k = 0; k <= kmax; k++) begin
                @(posedge clk);
                @(negedge clk);
                check_all(k);
            end
        end
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule